// File: doc/BRIEF.md
# JTAG Host Scan Sequencer

This block is the controlling side of a JTAG link. It takes one command at a time: force the target's test logic into reset, load an instruction of 1 to 32 bits, or scan a data register of 1 to 32 bits. It produces TCK from the system clock. It steers the target's controller with fixed TMS strings, presents the supplied vector on TDI, collects TDO into a result word, and marks the end of the command with a one-cycle done pulse.

Both scan commands assume the target starts in Run-Test/Idle, and both leave it there. The way back from the shift state always goes through the pause state rather than the shortest route. Each half period of TCK lasts a number of system clocks set by the caller. The reset input is asynchronous and active low, and it must be released in step with `clk`.

Top module: `jscan_host`

## Requirements
- R1: After reset, `tck` is 0, `tms` is 1, `tdi` is 0, `busy` is 0, `done` is 0 and `result` is 0.
- R2: `cmd_op` selects the command: 2'b00 is test-logic reset, 2'b01 is instruction load, 2'b10 is data scan, and 2'b11 behaves like 2'b00. A reset command gives exactly five TCK pulses with TMS at 1, and it leaves `result` unchanged.
- R3: An instruction load gives TMS 1,1,0,0 on its first four TCK pulses, then one pulse per vector bit with TMS at 0, then TMS 1,0,1,1,0, and no other pulse.
- R4: A data scan gives TMS 1,0,0 on its first three TCK pulses, then one pulse per vector bit with TMS at 0, then TMS 1,0,1,1,0, and no other pulse.
- R5: During the shift pulses TMS is 0. TDI carries `cmd_tdi` bit 0 on the first shift pulse, bit 1 on the next, and so on.
- R6: TDO is sampled at the end of the high phase of each shift pulse. The k-th sample goes to `result` bit k, and the bits at and above the length are 0. `result` changes only when a load or a scan completes.
- R7: On every pulse that is not a shift pulse, TDI holds the last bit shifted, or 0 if no bit has been shifted since reset.
- R8: While a command runs, every high phase and every low phase of TCK between pulses lasts `div_half` system clocks, and a value of 0 counts as 1. TMS and TDI change only while TCK is low.
- R9: A command is accepted when `cmd_valid` is 1 while `busy` is 0. `busy` is 1 from the next clock until the done pulse. A command offered while `busy` is 1 is ignored.
- R10: `done` is 1 for exactly one clock, in the clock where TCK falls after the last pulse of the command. In that same clock `busy` returns to 0.
- R11: A `cmd_len` of 0 is treated as 1, and a length above 32 is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Offer a command |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_len | input | 6 | Vector length in bits |
| cmd_tdi | input | 32 | Vector to shift out, LSB first |
| div_half | input | 8 | System clocks per TCK half period |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Captured TDO bits, LSB first |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Serial data to the target |
| tdo | input | 1 | Serial data from the target |

## Verification
Some properties are checked by assertions on every cycle: TCK stays low when the block is idle, TMS and TDI stay put while TCK is high, TMS is low in shift slots, done lasts one cycle and ends busy, and a command offered while idle raises busy. Other behaviour can only be shown by the bench's scenarios, which compare the traffic at each TCK rising edge against an expected queue. These include the exact TMS strings for each command, the TDI bit order and the value TDI holds between shifts, how TDO samples are placed in the result, the effect of length clamping and of the divider setting, and that a command offered while busy is ignored.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_IR    = 2'b01,
    OP_DR    = 2'b10,
    OP_ALT   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_SHIFT,
    PH_POST
  } phase_e;

  // TMS strings, bit 0 goes out first
  localparam logic [7:0] NAV_RST  = 8'b0001_1111;
  localparam logic [7:0] NAV_IR   = 8'b0000_0011;
  localparam logic [7:0] NAV_DR   = 8'b0000_0001;
  localparam logic [7:0] NAV_EXIT = 8'b0000_1101;
  localparam int unsigned EXIT_LEN = 5;

  function automatic logic [2:0] pre_len(op_e op);
    case (op)
      OP_IR:   return 3'd4;
      OP_DR:   return 3'd3;
      default: return 3'd5;
    endcase
  endfunction

  function automatic logic pre_tms(op_e op, logic [2:0] idx);
    case (op)
      OP_IR:   return NAV_IR[idx];
      OP_DR:   return NAV_DR[idx];
      default: return NAV_RST[idx];
    endcase
  endfunction

  function automatic logic has_shift(op_e op);
    return (op == OP_IR) || (op == OP_DR);
  endfunction

endpackage

// File: rtl/jscan_halfdiv.sv
module jscan_halfdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             tick
);

  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    lim  = (div_half == '0) ? DIV_W'(1) : div_half;
    tick = run && (cnt_q == lim - DIV_W'(1));
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

endmodule

// File: rtl/jscan_shreg.sv
module jscan_shreg #(
  parameter int unsigned MAX_BITS = 32,
  localparam int unsigned IDX_W   = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] load_vec,
  input  logic                pop,
  input  logic                sample,
  input  logic [IDX_W-1:0]    sample_idx,
  input  logic                tdo,
  output logic                pop_bit,
  output logic [MAX_BITS-1:0] rx_vec
);

  logic [MAX_BITS-1:0] tx_q, tx_d;
  logic [MAX_BITS-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load) begin
      tx_d = load_vec;
      rx_d = '0;
    end else begin
      if (pop)    tx_d = tx_q >> 1;
      if (sample) rx_d[sample_idx] = tdo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign pop_bit = tx_q[0];
  assign rx_vec  = rx_q;

  // R9
  load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(pop || sample));

endmodule

// File: rtl/jscan_ctrl.sv
module jscan_ctrl
  import jscan_pkg::*;
#(
  parameter int unsigned MAX_BITS = 32,
  localparam int unsigned LEN_W   = $clog2(MAX_BITS + 1),
  localparam int unsigned IDX_W   = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic                tick,
  input  logic                pop_bit,
  input  logic [MAX_BITS-1:0] rx_vec,
  output logic                load,
  output logic                pop,
  output logic                sample,
  output logic [IDX_W-1:0]    sample_idx,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] result,
  output logic                tck,
  output logic                tms,
  output logic                tdi
);

  phase_e              phase_q, phase_d;
  op_e                 op_q, op_d;
  logic [LEN_W-1:0]    len_q, len_d, idx_q, idx_d, eff_len;
  logic                tck_q, tck_d, tms_q, tms_d, tdi_q, tdi_d;
  logic                busy_q, busy_d, done_q, done_d;
  logic [MAX_BITS-1:0] res_q, res_d;
  logic                accept, finish;

  always_comb begin
    if (cmd_len == '0)                       eff_len = LEN_W'(1);
    else if (cmd_len > LEN_W'(MAX_BITS))     eff_len = LEN_W'(MAX_BITS);
    else                                     eff_len = cmd_len;
  end

  always_comb begin
    phase_d = phase_q;
    op_d    = op_q;
    len_d   = len_q;
    idx_d   = idx_q;
    tck_d   = tck_q;
    tms_d   = tms_q;
    tdi_d   = tdi_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    res_d   = res_q;
    load    = 1'b0;
    pop     = 1'b0;
    sample  = 1'b0;
    finish  = 1'b0;
    accept  = cmd_valid && !busy_q;

    if (accept) begin
      op_d    = op_e'(cmd_op);
      len_d   = eff_len;
      phase_d = PH_PRE;
      idx_d   = '0;
      busy_d  = 1'b1;
      tck_d   = 1'b0;
      tms_d   = pre_tms(op_e'(cmd_op), 3'd0);
      load    = 1'b1;
    end else if (busy_q && tick) begin
      if (!tck_q) begin
        tck_d = 1'b1;
      end else begin
        tck_d = 1'b0;
        if (phase_q == PH_SHIFT) sample = 1'b1;
        case (phase_q)
          PH_PRE: begin
            if (idx_q == LEN_W'(pre_len(op_q) - 3'd1)) begin
              if (has_shift(op_q)) begin
                phase_d = PH_SHIFT;
                idx_d   = '0;
                tms_d   = 1'b0;
                pop     = 1'b1;
                tdi_d   = pop_bit;
              end else begin
                finish = 1'b1;
              end
            end else begin
              idx_d = idx_q + LEN_W'(1);
              tms_d = pre_tms(op_q, idx_q[2:0] + 3'd1);
            end
          end
          PH_SHIFT: begin
            if (idx_q == len_q - LEN_W'(1)) begin
              phase_d = PH_POST;
              idx_d   = '0;
              tms_d   = NAV_EXIT[0];
            end else begin
              idx_d = idx_q + LEN_W'(1);
              tms_d = 1'b0;
              pop   = 1'b1;
              tdi_d = pop_bit;
            end
          end
          PH_POST: begin
            if (idx_q == LEN_W'(EXIT_LEN - 1)) begin
              finish = 1'b1;
            end else begin
              idx_d = idx_q + LEN_W'(1);
              tms_d = NAV_EXIT[idx_q[2:0] + 3'd1];
            end
          end
          default: finish = 1'b1;
        endcase
        if (finish) begin
          phase_d = PH_IDLE;
          busy_d  = 1'b0;
          done_d  = 1'b1;
          if (has_shift(op_q)) res_d = rx_vec;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_RESET;
      len_q   <= '0;
      idx_q   <= '0;
      tck_q   <= 1'b0;
      tms_q   <= 1'b1;
      tdi_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      phase_q <= phase_d;
      op_q    <= op_d;
      len_q   <= len_d;
      idx_q   <= idx_d;
      tck_q   <= tck_d;
      tms_q   <= tms_d;
      tdi_q   <= tdi_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      res_q   <= res_d;
    end
  end

  assign sample_idx = idx_q[IDX_W-1:0];
  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
  assign tck    = tck_q;
  assign tms    = tms_q;
  assign tdi    = tdi_q;

  // R8
  idle_tck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !tck_q);

  // R8
  pins_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tck_q |-> ($stable(tms_q) && $stable(tdi_q)));

  // R5
  shift_tms_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SHIFT) |-> !tms_q);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy_q) |=> busy_q);

endmodule

// File: rtl/jscan_host.sv
module jscan_host #(
  parameter int unsigned MAX_BITS = 32,
  parameter int unsigned DIV_W    = 8,
  localparam int unsigned LEN_W   = $clog2(MAX_BITS + 1),
  localparam int unsigned IDX_W   = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic [MAX_BITS-1:0] cmd_tdi,
  input  logic [DIV_W-1:0]    div_half,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] result,
  output logic                tck,
  output logic                tms,
  output logic                tdi,
  input  logic                tdo
);

  logic                tick, load, pop, sample, pop_bit;
  logic [IDX_W-1:0]    sample_idx;
  logic [MAX_BITS-1:0] rx_vec;

  jscan_halfdiv #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .div_half (div_half),
    .tick     (tick)
  );

  jscan_shreg #(.MAX_BITS(MAX_BITS)) u_shreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_vec   (cmd_tdi),
    .pop        (pop),
    .sample     (sample),
    .sample_idx (sample_idx),
    .tdo        (tdo),
    .pop_bit    (pop_bit),
    .rx_vec     (rx_vec)
  );

  jscan_ctrl #(.MAX_BITS(MAX_BITS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_len    (cmd_len),
    .tick       (tick),
    .pop_bit    (pop_bit),
    .rx_vec     (rx_vec),
    .load       (load),
    .pop        (pop),
    .sample     (sample),
    .sample_idx (sample_idx),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .tck        (tck),
    .tms        (tms),
    .tdi        (tdi)
  );

endmodule

// File: tb/jscan_host_bench.sv
module jscan_host_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [5:0]  cmd_len = '0;
  logic [31:0] cmd_tdi = '0;
  logic [7:0]  div_half = 8'd1;
  logic        busy, done, tck, tms, tdi;
  logic [31:0] result;
  logic        tdo = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  logic [1:0]  exp_pin[$];   // {tms, tdi} per TCK rise
  logic [31:0] exp_res[$];
  logic [63:0] tdo_pat = '0;
  int          rise_idx = 0;
  int          eff_div = 1;
  logic        low_from_fall = 1'b0;
  logic        prev_tck = 1'b0;
  int          run_len = 0;
  logic        last_tdi = 1'b0;
  logic [31:0] model_res = '0;
  logic        done_seen = 1'b0;

  always #5 clk = ~clk;

  jscan_host u_jscan_host (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_len(cmd_len), .cmd_tdi(cmd_tdi), .div_half(div_half),
    .busy(busy), .done(done), .result(result),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Monitor: pin values at each TCK rise
  always @(posedge tck) begin
    #1;
    if (exp_pin.size() == 0) begin
      check(1'b0, "R3/R4 extra TCK pulse", {30'd0, tms, tdi}, 32'd0);
    end else begin
      logic [1:0] e;
      e = exp_pin.pop_front();
      check(tms === e[1], "R2/R3/R4/R5 TMS", {31'd0, tms}, {31'd0, e[1]});
      check(tdi === e[0], "R5/R7 TDI", {31'd0, tdi}, {31'd0, e[0]});
    end
    tdo = tdo_pat[rise_idx % 64];
    rise_idx++;
  end

  // Monitor: phase lengths and completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (tck === prev_tck) run_len++;
      else begin
        if (prev_tck) check(run_len == eff_div, "R8 high phase", run_len, eff_div);
        else if (low_from_fall) check(run_len == eff_div, "R8 low phase", run_len, eff_div);
        low_from_fall = prev_tck;
        prev_tck = tck;
        run_len = 1;
      end
      if (done_seen) begin
        check(done === 1'b0, "R10 done width", {31'd0, done}, 32'd0);
        done_seen = 1'b0;
      end
      if (done === 1'b1) begin
        logic [31:0] er;
        done_seen = 1'b1;
        check(busy === 1'b0, "R10 busy at done", {31'd0, busy}, 32'd0);
        check(tck === 1'b0, "R10 tck falls at done", {31'd0, tck}, 32'd0);
        check(exp_pin.size() == 0, "R3/R4 pulse count", exp_pin.size(), 32'd0);
        er = (exp_res.size() != 0) ? exp_res.pop_front() : 32'hx;
        check(result === er, "R6 result", result, er);
      end
    end
  end

  // Driver: pushes expected pin values and result, then issues command
  task automatic run_cmd(input logic [1:0] op, input logic [5:0] len,
                         input logic [31:0] vec, input logic [7:0] dv,
                         input logic [63:0] pat, input bit inject);
    int n;
    int pre;
    logic [7:0] nav;
    n   = (len == 0) ? 1 : (len > 32) ? 32 : int'(len);   // R11
    nav = (op == 2'b01) ? 8'b0000_0011 : (op == 2'b10) ? 8'b0000_0001 : 8'b0001_1111;
    pre = (op == 2'b01) ? 4 : (op == 2'b10) ? 3 : 5;
    for (int i = 0; i < pre; i++) exp_pin.push_back({nav[i], last_tdi});
    if (op == 2'b01 || op == 2'b10) begin
      for (int i = 0; i < n; i++) exp_pin.push_back({1'b0, vec[i]});
      last_tdi = vec[n-1];
      for (int i = 0; i < 5; i++) exp_pin.push_back({8'b0000_1101 >> i, last_tdi} & 2'b11 | {1'b0, last_tdi});
      model_res = '0;
      for (int i = 0; i < n; i++) model_res[i] = pat[pre + i];
    end
    exp_res.push_back(model_res);
    @(negedge clk);
    tdo_pat = pat;
    rise_idx = 0;
    low_from_fall = 1'b0;
    eff_div = (dv == 0) ? 1 : int'(dv);
    div_half = dv;
    cmd_op = op; cmd_len = len; cmd_tdi = vec; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy === 1'b1, "R9 busy after accept", {31'd0, busy}, 32'd1);
    if (inject) begin
      repeat (3) @(negedge clk);
      cmd_op = 2'b10; cmd_len = 6'd7; cmd_tdi = 32'hFFFF_FFFF; cmd_valid = 1'b1;  // R9 ignored
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(tck === 1'b0 && tms === 1'b1 && tdi === 1'b0, "R1 pins", {29'd0, tck, tms, tdi}, 32'd2);
    check(busy === 1'b0 && done === 1'b0, "R1 flags", {30'd0, busy, done}, 32'd0);
    check(result === 32'd0, "R1 result", result, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tck === 1'b0 && busy === 1'b0, "R1 idle after release", {30'd0, tck, busy}, 32'd0);
    // R2 reset command, result unchanged
    run_cmd(2'b00, 6'd0, 32'd0, 8'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    // R3 instruction load
    run_cmd(2'b01, 6'd8, 32'h0000_00A5, 8'd1, 64'h0123_4567_89AB_CDEF, 1'b0);
    // R4 data scan at full length, slower clock
    run_cmd(2'b10, 6'd32, 32'hDEAD_BEEF, 8'd3, 64'hF0E1_D2C3_B4A5_9687, 1'b0);
    // R2 reset keeps result, R7 tdi held
    run_cmd(2'b00, 6'd5, 32'd0, 8'd2, 64'd0, 1'b0);
    // R4 one-bit scan
    run_cmd(2'b10, 6'd1, 32'h0000_0000, 8'd2, 64'h0000_0000_0000_0008, 1'b0);
    // R11 length zero
    run_cmd(2'b10, 6'd0, 32'h0000_0001, 8'd1, 64'h0000_0000_0000_0000, 1'b0);
    // R11 length above maximum
    run_cmd(2'b10, 6'd40, 32'h8000_0001, 8'd1, 64'hAAAA_5555_3333_CCCC, 1'b0);
    // R2 alternate reset code
    run_cmd(2'b11, 6'd9, 32'hFFFF_FFFF, 8'd1, 64'd0, 1'b0);
    // R8 divider zero, R9 command while busy ignored
    run_cmd(2'b01, 6'd5, 32'h0000_0016, 8'd0, 64'h1357_9BDF_0246_8ACE, 1'b1);
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && tck === 1'b0, "R9 no extra command", {30'd0, busy, tck}, 32'd0);
    check(exp_pin.size() == 0, "R9 no extra pulses", exp_pin.size(), 32'd0);
    summary();
  end

endmodule